// File: doc/BRIEF.md
# Memory chip-select timing sequencer

This block produces the chip-select and clock-gating sequence for one access of a double-data-rate memory controller that talks to either a RAM or a flash device. It holds one 32-bit timing word. The word has separate read and write codes for three intervals: select setup, select hold and the high gap between accesses. It also has an initial-latency code that only applies to RAM devices. A requester raises `req` with a direction and a beat count. The sequencer then lowers `cs_n`, waits the setup time and enables the memory clock. The clock runs through the command/address phase, the latency phase and the data beats. The sequencer then holds the select low and keeps it high for the programmed gap before it takes the next request.

The block runs on `clk`, which is twice the memory clock rate, so one `clk` period is half a memory clock. Every interval is counted in these half-cycles, which lets the gap carry its extra half cycle exactly. Command shifting, strobe capture and the data path are handled elsewhere. The direction, device type, beat count and selected codes are captured when a request is accepted.

Top module: `cst_timing_seq`

## Requirements
- R1: After a synchronous reset, `cfg_rdata` reads 32'h0000_0001, `cs_n` is 1, and `ck_en`, `busy`, `done` and `lat_err` are 0.
- R2: A write via `cfg_we` stores `cfg_wdata`. Bits 7:4 always read back as zero. The field positions are: read gap [31:28], write gap [27:24], read setup [23:20], write setup [19:16], read hold [15:12], write hold [11:8], latency code [3:0].
- R3: A setup code n keeps `cs_n` low with `ck_en` low for n+1 memory clocks (2n+2 `clk` cycles) before `ck_en` rises.
- R4: `ck_en` stays high for 3 + L + B memory clocks, where 3 is the fixed command/address phase, L is the decoded latency and B is `req_beats`.
- R5: Latency codes decode as 4'b0000 to 5 clocks, 4'b0001 to 6, 4'b1110 to 3 and 4'b1111 to 4.
- R6: When `dev_flash` is 1 at acceptance, no latency phase is inserted (L = 0) and the latency code has no effect.
- R7: A hold code n keeps `cs_n` low for n+1 memory clocks (2n+2 `clk` cycles) after `ck_en` falls.
- R8: A gap code n keeps `cs_n` high for n+1.5 memory clocks between back-to-back accesses (2n+3 `clk` cycles), of which 2n+2 cycles have `busy` high.
- R9: `req_wr` = 1 selects the write setup, hold and gap codes, and `req_wr` = 0 selects the read codes.
- R10: A reserved latency code (4'b0010 to 4'b1101) on a RAM access acts as 6 clocks and sets `lat_err`, which then stays set until reset. The same code on a flash access does not set it.
- R11: `done` pulses for exactly one `clk` cycle per access, in the first cycle `cs_n` is high again.
- R12: `req` is accepted only while `busy` is 0. A request that is asserted and dropped while `busy` is high starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Current timing word |
| dev_flash | input | 1 | 1 = flash device, which has no latency phase |
| req | input | 1 | Access request, a level that is taken when idle |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_beats | input | BEAT_W | Number of data beats in memory clocks |
| busy | output | 1 | Access or gap in progress |
| done | output | 1 | One-cycle pulse when the select is released |
| cs_n | output | 1 | Active-low chip select, registered |
| ck_en | output | 1 | Memory clock enable, registered |
| lat_err | output | 1 | Sticky reserved-latency-code flag |

## Verification
The bench applies a request and times each phase from the accepting edge. `cs_n` falls at that same edge, so the first sample of the setup phase falls at the next falling edge of `clk`. Every later interval is measured by counting falling edges while the output pair (`cs_n`, `ck_en`, `busy`) stays in one phase. The result is compared with 2n+2 half-cycles for setup and hold, 2(3+L+B) for the clock phase and 2n+2 for the busy part of the gap. `done` is looked for within those gap samples. The back-to-back case counts the full high time of `cs_n` with `req` held, and expects 2n+3 cycles. Register and flag results are read one `clk` after the write or the accepting edge that causes them.

// File: rtl/cst_pkg.sv
package cst_pkg;

    localparam int CFG_W       = 32;
    localparam int CODE_W      = 4;
    localparam int LAT_W       = 3;
    localparam int CA_CLOCKS   = 3;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_HOLD,
        ST_GAP
    } cst_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] rd_gap;
        logic [CODE_W-1:0] wr_gap;
        logic [CODE_W-1:0] rd_setup;
        logic [CODE_W-1:0] wr_setup;
        logic [CODE_W-1:0] rd_hold;
        logic [CODE_W-1:0] wr_hold;
        logic [CODE_W-1:0] spare;
        logic [CODE_W-1:0] lat_code;
    } cst_cfg_t;

    typedef struct packed {
        logic [CODE_W-1:0] setup;
        logic [CODE_W-1:0] hold;
        logic [CODE_W-1:0] gap;
        logic [LAT_W-1:0]  lat_clk;
        logic              bad_code;
    } cst_sel_t;

    function automatic logic [LAT_W-1:0] lat_clocks(input logic [CODE_W-1:0] code);
        case (code)
            4'b0000: lat_clocks = 3'd5;
            4'b0001: lat_clocks = 3'd6;
            4'b1110: lat_clocks = 3'd3;
            4'b1111: lat_clocks = 3'd4;
            default: lat_clocks = 3'd6;
        endcase
    endfunction

    function automatic logic lat_reserved(input logic [CODE_W-1:0] code);
        lat_reserved = !(code inside {4'b0000, 4'b0001, 4'b1110, 4'b1111});
    endfunction

endpackage

// File: rtl/cst_cfg_reg.sv
module cst_cfg_reg
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cst_cfg_t         cfg
);

    cst_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cst_cfg_t'(CFG_RESET);
        end else if (we) begin
            cfg_q       <= cst_cfg_t'(wdata);
            cfg_q.spare <= '0;
        end
    end

    assign cfg = cfg_q;

    a_r2_spare_zero: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg.spare == '0));

endmodule

// File: rtl/cst_code_sel.sv
module cst_code_sel
    import cst_pkg::*;
(
    input  logic [CODE_W-1:0] rd_setup,
    input  logic [CODE_W-1:0] wr_setup,
    input  logic [CODE_W-1:0] rd_hold,
    input  logic [CODE_W-1:0] wr_hold,
    input  logic [CODE_W-1:0] rd_gap,
    input  logic [CODE_W-1:0] wr_gap,
    input  logic [CODE_W-1:0] lat_code,
    input  logic              is_wr,
    input  logic              is_flash,
    output cst_sel_t          sel
);

    always_comb begin
        sel.setup = is_wr ? wr_setup : rd_setup;
        sel.hold  = is_wr ? wr_hold  : rd_hold;
        sel.gap   = is_wr ? wr_gap   : rd_gap;
        if (is_flash) begin
            sel.lat_clk  = '0;
            sel.bad_code = 1'b0;
        end else begin
            sel.lat_clk  = lat_clocks(lat_code);
            sel.bad_code = lat_reserved(lat_code);
        end
    end

endmodule

// File: rtl/cst_seq_fsm.sv
module cst_seq_fsm
    import cst_pkg::*;
#(
    parameter int BEAT_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [BEAT_W-1:0] beats,
    input  cst_sel_t          sel,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              ck_en,
    output logic              lat_err
);

    localparam int CNT_W = BEAT_W + 4;

    cst_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CODE_W-1:0] hold_q, gap_q;
    logic [LAT_W-1:0]  lat_q;
    logic [BEAT_W-1:0] beats_q;
    logic              done_q, cs_n_q, ck_en_q, err_q;
    logic [CNT_W-1:0]  act_clks, act_load;
    logic              accept, last;

    assign accept   = (state_q == ST_IDLE) && req;
    assign last     = (cnt_q == '0);
    assign act_clks = CNT_W'(CA_CLOCKS) + CNT_W'(lat_q) + CNT_W'(beats_q);
    assign act_load = {act_clks[CNT_W-2:0], 1'b0} - CNT_W'(1);

    always_comb begin
        state_d = state_q;
        cnt_d   = last ? cnt_q : cnt_q - CNT_W'(1);
        case (state_q)
            ST_IDLE: begin
                cnt_d = cnt_q;
                if (req) begin
                    state_d = ST_SETUP;
                    cnt_d   = CNT_W'({sel.setup, 1'b1});
                end
            end
            ST_SETUP: if (last) begin
                state_d = ST_ACTIVE;
                cnt_d   = act_load;
            end
            ST_ACTIVE: if (last) begin
                state_d = ST_HOLD;
                cnt_d   = CNT_W'({hold_q, 1'b1});
            end
            ST_HOLD: if (last) begin
                state_d = ST_GAP;
                cnt_d   = CNT_W'({gap_q, 1'b1});
            end
            ST_GAP: if (last) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
            gap_q   <= '0;
            lat_q   <= '0;
            beats_q <= '0;
            done_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            ck_en_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                hold_q  <= sel.hold;
                gap_q   <= sel.gap;
                lat_q   <= sel.lat_clk;
                beats_q <= beats;
            end
            done_q  <= (state_q == ST_HOLD) && last;
            cs_n_q  <= !(state_d inside {ST_SETUP, ST_ACTIVE, ST_HOLD});
            ck_en_q <= (state_d == ST_ACTIVE);
            err_q   <= err_q | (accept & sel.bad_code);
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign cs_n    = cs_n_q;
    assign ck_en   = ck_en_q;
    assign lat_err = err_q;

    a_r3_no_clk_at_select: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !ck_en);
    a_r4_clk_inside_select: assert property (@(posedge clk) disable iff (rst)
        ck_en |-> !cs_n);
    a_r7_select_after_clk: assert property (@(posedge clk) disable iff (rst)
        $fell(ck_en) |-> !cs_n);
    a_r8_gap_is_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> busy);
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        lat_err |=> lat_err);
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r12_accept_when_idle: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> (busy && !cs_n));

endmodule

// File: rtl/cst_timing_seq.sv
module cst_timing_seq
    import cst_pkg::*;
#(
    parameter int BEAT_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              dev_flash,
    input  logic              req,
    input  logic              req_wr,
    input  logic [BEAT_W-1:0] req_beats,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              ck_en,
    output logic              lat_err
);

    cst_cfg_t cfg;
    cst_sel_t sel;

    cst_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    cst_code_sel u_sel (
        .rd_setup (cfg.rd_setup),
        .wr_setup (cfg.wr_setup),
        .rd_hold  (cfg.rd_hold),
        .wr_hold  (cfg.wr_hold),
        .rd_gap   (cfg.rd_gap),
        .wr_gap   (cfg.wr_gap),
        .lat_code (cfg.lat_code),
        .is_wr    (req_wr),
        .is_flash (dev_flash),
        .sel      (sel)
    );

    cst_seq_fsm #(.BEAT_W(BEAT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .beats   (req_beats),
        .sel     (sel),
        .busy    (busy),
        .done    (done),
        .cs_n    (cs_n),
        .ck_en   (ck_en),
        .lat_err (lat_err)
    );

    assign cfg_rdata = cfg;

endmodule

// File: tb/cst_timing_seq_test.sv
module cst_timing_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dev_flash = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [7:0]  req_beats = '0;
    logic        busy, done, cs_n, ck_en, lat_err;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    cst_timing_seq #(.BEAT_W(8)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dev_flash(dev_flash), .req(req),
        .req_wr(req_wr), .req_beats(req_beats), .busy(busy), .done(done),
        .cs_n(cs_n), .ck_en(ck_en), .lat_err(lat_err)
    );

    // {cfg, wr, flash, beats, setup, active, hold, gap} in clk cycles
    localparam logic [81:0] VEC [0:6] = '{
        {32'h0000_0001, 1'b0, 1'b0, 8'd4, 8'd2,  16'd26, 8'd2,  8'd2},
        {32'h5A3C_7200, 1'b0, 1'b0, 8'd2, 8'd8,  16'd20, 8'd16, 8'd12},
        {32'h5A3C_7200, 1'b1, 1'b0, 8'd2, 8'd26, 16'd20, 8'd6,  8'd22},
        {32'hF0F0_F00E, 1'b0, 1'b0, 8'd1, 8'd32, 16'd14, 8'd32, 8'd32},
        {32'hF0F0_F00E, 1'b1, 1'b0, 8'd0, 8'd2,  16'd12, 8'd2,  8'd2},
        {32'h1234_567F, 1'b1, 1'b0, 8'd3, 8'd10, 16'd20, 8'd14, 8'd6},
        {32'h1234_567F, 1'b0, 1'b1, 8'd3, 8'd8,  16'd12, 8'd12, 8'd4}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_txn(input logic wr, input logic fl, input logic [7:0] b,
                           output int su, output int ac, output int ho,
                           output int ga, output int dn);
        @(negedge clk);
        req = 1'b1; req_wr = wr; dev_flash = fl; req_beats = b;
        @(negedge clk);
        req = 1'b0;
        su = 0; ac = 0; ho = 0; ga = 0; dn = 0;
        while (!cs_n && !ck_en && su < 5000) begin su++; @(negedge clk); end
        while (ck_en && ac < 5000) begin ac++; @(negedge clk); end
        while (!cs_n && !ck_en && ho < 5000) begin ho++; @(negedge clk); end
        while (busy && cs_n && ga < 5000) begin
            if (done) dn++;
            ga++;
            @(negedge clk);
        end
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int su, ac, ho, ga, dn;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 32'h0000_0001, "R1 cfg reset", cfg_rdata, 1);
        check(cs_n && !ck_en && !busy && !done && !lat_err, "R1 outputs idle",
              {cs_n, ck_en, busy, done, lat_err}, 5'b10000);

        // R2 spare bits read zero
        write_cfg(32'h5A3C_72F0);
        check(cfg_rdata == 32'h5A3C_7200, "R2 readback", cfg_rdata, 32'h5A3C_7200);

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R11
        for (int i = 0; i < 7; i++) begin
            logic [81:0] v;
            v = VEC[i];
            write_cfg(v[81:50]);
            run_txn(v[49], v[48], v[47:40], su, ac, ho, ga, dn);
            check(su == int'(v[39:32]), $sformatf("R3 R9 setup vec%0d", i), su, v[39:32]);
            check(ac == int'(v[31:16]), $sformatf("R4 R5 R6 active vec%0d", i), ac, v[31:16]);
            check(ho == int'(v[15:8]), $sformatf("R7 R9 hold vec%0d", i), ho, v[15:8]);
            check(ga == int'(v[7:0]), $sformatf("R8 R9 gap vec%0d", i), ga, v[7:0]);
            check(dn == 1, $sformatf("R11 done pulses vec%0d", i), dn, 1);
            check(!busy && cs_n, $sformatf("R8 idle after vec%0d", i), busy, 0);
        end

        // R10 reserved code on flash: no error, no latency
        write_cfg(32'h0000_0005);
        run_txn(1'b0, 1'b1, 8'd1, su, ac, ho, ga, dn);
        check(ac == 8, "R6 flash reserved code active", ac, 8);
        check(lat_err == 1'b0, "R10 flash no error", lat_err, 0);
        // R10 reserved code on RAM: 6 clocks and sticky flag
        run_txn(1'b0, 1'b0, 8'd1, su, ac, ho, ga, dn);
        check(ac == 20, "R10 reserved acts as 6", ac, 20);
        check(lat_err == 1'b1, "R10 flag set", lat_err, 1);
        write_cfg(32'h0000_0001);
        run_txn(1'b1, 1'b0, 8'd0, su, ac, ho, ga, dn);
        check(lat_err == 1'b1, "R10 flag sticky", lat_err, 1);
        check(ac == 18, "R5 code 0001 six clocks", ac, 18);

        // R8 back-to-back gap of 2n+3 cycles with req held
        write_cfg(32'h3000_0001);
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; dev_flash = 1'b0; req_beats = 8'd0;
        begin
            int k, hi;
            k = 0; hi = 0;
            while (cs_n && k < 5000) begin k++; @(negedge clk); end
            while (!cs_n && k < 5000) begin k++; @(negedge clk); end
            while (cs_n && hi < 5000) begin hi++; @(negedge clk); end
            req = 1'b0;
            check(hi == 9, "R8 back-to-back high time", hi, 9);
            while (busy && k < 10000) begin k++; @(negedge clk); end
        end

        // R12 request pulsed while busy is dropped
        write_cfg(32'h0000_0001);
        @(negedge clk);
        req = 1'b1; req_beats = 8'd4;
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R12 busy during access", busy, 1);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        begin
            int k;
            k = 0;
            while (busy && k < 5000) begin k++; @(negedge clk); end
        end
        begin
            int starts;
            starts = 0;
            for (int j = 0; j < 12; j++) begin
                if (busy || !cs_n) starts++;
                @(negedge clk);
            end
            check(starts == 0, "R12 no access after drop", starts, 0);
        end

        // R1 reset clears the sticky flag and timing word
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(lat_err == 1'b0 && cfg_rdata == 32'h0000_0001, "R1 reset again",
              cfg_rdata, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule